// File: doc/BRIEF.md
# Simultaneous-Sampling ADC Capture Controller

This block drives the conversion handshake of an external multi-channel converter that samples all of its inputs at once. A rising conversion-start line begins a conversion. The converter raises its busy line while it works and drops it once every channel is done. The falling busy edge starts readout. The controller then fetches one 16-bit word per channel with a low-active read strobe. It checks the converter's first-word flag on the first word of every frame. Each accepted word goes out as one beat of a valid/ready stream, tagged with its channel number, and a last flag marks the final channel.

Conversions run either one at a time on a start pulse or back to back while continuous mode is held. In continuous mode the start line drops as soon as busy falls and rises again once the last beat of the frame has been accepted. A frame whose first word arrives without the first-word flag is discarded. In that case the controller pulses the converter's reset line and reports an alignment error. A single-shot conversion that never finishes is abandoned after a timeout.

The controller also drives the oversampling index pins and the input-span pin. When so configured, it resets the converter after every oversampling change and waits out a settling delay before the next conversion.

Top module: `simul_adc_capture`

## Requirements
- R1: While rst_n is low: conv_start is 0, rd_n is 1, adc_reset is 0, out_valid is 0, os_pins is 0, and both error pulses are 0.
- R2: A one-cycle start_single pulse in idle raises conv_start. After busy falls, NUM_CH words are read and each is offered as one beat. out_ch counts 0 to NUM_CH-1, out_data equals the word read for that channel, and out_last is 1 only on channel NUM_CH-1. conv_start is 0 in the cycle after the final beat is accepted.
- R3: Each word read drives rd_n low for exactly RD_LOW_CYC cycles. rd_n stays high at least RD_HIGH_CYC cycles between reads. The word is taken from rd_data at the clock edge where rd_n returns high.
- R4: In continuous mode (cont_en high), conv_start is 0 in the cycle after busy is seen falling. If cont_en is still high, conv_start is 1 in the cycle after the frame's final beat is accepted.
- R5: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_ch hold. conv_start does not rise while a beat is pending.
- R6: If first_data is 0 when the channel-0 word is taken, no beat of that frame is sent. err_align pulses for one cycle, and adc_reset is 1 in that same cycle.
- R7: Every adc_reset pulse lasts exactly RST_CYC cycles. With POST_OS_RESET set, conv_start rises no sooner than INIT_DLY_CYC+1 cycles after adc_reset falls.
- R8: In single-shot mode, if busy has not fallen TIMEOUT_CYC cycles after conv_start rose, err_timeout pulses for one cycle and conv_start is 0 in that cycle.
- R9: os_sel is taken over onto os_pins while idle. Index k selects a ratio of 2^k. Index 7 is allowed only when NUM_CH is 16 and becomes 6 otherwise. With POST_OS_RESET set, every change of os_pins is followed by an adc_reset pulse.
- R10: range_pin is 0 for the smaller span and 1 for the larger. It follows range_sel one cycle later, and is forced to 1 one cycle after standby is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_single | input | 1 | Pulse: run one conversion and readout |
| cont_en | input | 1 | Level: run conversions back to back |
| os_sel | input | 3 | Requested oversampling index |
| range_sel | input | 1 | Requested input span (1 = larger) |
| standby | input | 1 | Standby request; forces the span pin high |
| busy | input | 1 | Converter busy line |
| first_data | input | 1 | Converter first-word flag |
| rd_data | input | DATA_W | Converter parallel data word |
| conv_start | output | 1 | Conversion-start line to the converter |
| rd_n | output | 1 | Read strobe, active low |
| adc_reset | output | 1 | Converter reset pulse |
| os_pins | output | 3 | Oversampling index pins |
| range_pin | output | 1 | Input span pin |
| out_data | output | DATA_W | Stream beat: channel word |
| out_ch | output | CH_W | Stream beat: channel number |
| out_valid | output | 1 | Stream beat valid |
| out_last | output | 1 | Beat is the frame's final channel |
| out_ready | input | 1 | Stream sink ready |
| err_align | output | 1 | One-cycle pulse: misaligned frame dropped |
| err_timeout | output | 1 | One-cycle pulse: single-shot conversion timed out |

## Verification
A converter model answers conv_start after a random latency. It hands out per-frame, per-channel words drawn from a random salt, so a swapped channel, a stale frame or a late capture shows up in the data. Single-shot frames with a steady and then a random ready pattern separate the plain handshake from stream flow control. A long continuous run with random back-pressure, plus a directed long stall, shows whether re-triggering waits for the sink. Directed cases cover the remaining behaviours: a missing first-word flag, a converter that never answers, and oversampling changes including the disallowed index 7. Together they exercise the drop-and-reset path, the timeout and the settling wait.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    localparam int OS_W = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RST,
        ST_INIT,
        ST_CONV,
        ST_READ,
        ST_SEND
    } ctl_state_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } rd_phase_e;

endpackage

// File: rtl/sadc_strobe_reader.sv
module sadc_strobe_reader
    import sadc_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int LOW_CYC  = 2,
    parameter int HIGH_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [DATA_W-1:0] rd_data,
    input  logic              first_data,
    output logic              rd_n,
    output logic              done,
    output logic [DATA_W-1:0] word,
    output logic              first_flag
);

    localparam int CMAX = (LOW_CYC > HIGH_CYC) ? LOW_CYC : HIGH_CYC;
    localparam int CW   = $clog2(CMAX + 1);

    typedef struct packed {
        rd_phase_e         ph;
        logic [CW-1:0]     cnt;
        logic              rd_n;
        logic [DATA_W-1:0] word;
        logic              fd;
        logic              done;
    } rd_st_t;

    rd_st_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.ph)
            PH_IDLE: begin
                if (go) begin
                    d.ph   = PH_LOW;
                    d.rd_n = 1'b0;
                    d.cnt  = CW'(LOW_CYC - 1);
                end
            end
            PH_LOW: begin
                if (q.cnt == '0) begin
                    d.rd_n = 1'b1;
                    d.word = rd_data;
                    d.fd   = first_data;
                    d.ph   = PH_HIGH;
                    d.cnt  = CW'(HIGH_CYC - 1);
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_HIGH: begin
                if (q.cnt == '0) begin
                    d.done = 1'b1;
                    d.ph   = PH_IDLE;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.ph   <= PH_IDLE;
            q.rd_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_n       = q.rd_n;
    assign done       = q.done;
    assign word       = q.word;
    assign first_flag = q.fd;

    AST_DONE_STROBE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rd_n) else $error("done with strobe low"); // R3

endmodule

// File: rtl/sadc_os_encode.sv
module sadc_os_encode
    import sadc_pkg::*;
#(
    parameter int NUM_CH = 8
) (
    input  logic [OS_W-1:0] req,
    output logic [OS_W-1:0] idx
);

    generate
        if (NUM_CH == 16) begin : g_wide
            assign idx = req;
        end else begin : g_narrow
            assign idx = (req == OS_W'(7)) ? OS_W'(6) : req;
        end
    endgenerate

endmodule

// File: rtl/simul_adc_capture.sv
module simul_adc_capture
    import sadc_pkg::*;
#(
    parameter int NUM_CH        = 8,
    parameter int DATA_W        = 16,
    parameter int RD_LOW_CYC    = 2,
    parameter int RD_HIGH_CYC   = 2,
    parameter int RST_CYC       = 5,
    parameter int TIMEOUT_CYC   = 50_000_000,
    parameter int INIT_DLY_CYC  = 750_000,
    parameter bit POST_OS_RESET = 1'b1,
    localparam int CH_W         = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_single,
    input  logic              cont_en,
    input  logic [2:0]        os_sel,
    input  logic              range_sel,
    input  logic              standby,
    input  logic              busy,
    input  logic              first_data,
    input  logic [DATA_W-1:0] rd_data,
    output logic              conv_start,
    output logic              rd_n,
    output logic              adc_reset,
    output logic [2:0]        os_pins,
    output logic              range_pin,
    output logic [DATA_W-1:0] out_data,
    output logic [CH_W-1:0]   out_ch,
    output logic              out_valid,
    output logic              out_last,
    input  logic              out_ready,
    output logic              err_align,
    output logic              err_timeout
);

    localparam int TM1  = (TIMEOUT_CYC > INIT_DLY_CYC) ? TIMEOUT_CYC : INIT_DLY_CYC;
    localparam int TMAX = (TM1 > RST_CYC) ? TM1 : RST_CYC;
    localparam int TW   = $clog2(TMAX + 1);

    typedef struct packed {
        ctl_state_e        st;
        logic              cv;
        logic              arst;
        logic              cont;
        logic [TW-1:0]     tmr;
        logic [CH_W-1:0]   ch;
        logic [OS_W-1:0]   os;
        logic              rng;
        logic              busy_q;
        logic [DATA_W-1:0] word;
        logic              vld;
        logic              err_a;
        logic              err_t;
    } ctl_st_t;

    ctl_st_t q, d;

    logic              rd_go, rd_done, rd_first;
    logic [DATA_W-1:0] rd_word;
    logic [OS_W-1:0]   os_idx;
    logic              busy_fell;

    sadc_strobe_reader #(
        .DATA_W  (DATA_W),
        .LOW_CYC (RD_LOW_CYC),
        .HIGH_CYC(RD_HIGH_CYC)
    ) reader_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (rd_go),
        .rd_data   (rd_data),
        .first_data(first_data),
        .rd_n      (rd_n),
        .done      (rd_done),
        .word      (rd_word),
        .first_flag(rd_first)
    );

    sadc_os_encode #(.NUM_CH(NUM_CH)) os_enc_i (
        .req(os_sel),
        .idx(os_idx)
    );

    assign busy_fell = q.busy_q & ~busy;

    always_comb begin
        d        = q;
        d.err_a  = 1'b0;
        d.err_t  = 1'b0;
        d.busy_q = busy;
        d.rng    = standby | range_sel;
        rd_go    = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (os_idx != q.os) begin
                    d.os = os_idx;
                    if (POST_OS_RESET) begin
                        d.st   = ST_RST;
                        d.arst = 1'b1;
                        d.tmr  = TW'(RST_CYC - 1);
                    end
                end else if (start_single || cont_en) begin
                    d.st   = ST_CONV;
                    d.cv   = 1'b1;
                    d.cont = !start_single;
                    d.tmr  = TW'(TIMEOUT_CYC - 1);
                end
            end
            ST_RST: begin
                if (q.tmr == '0) begin
                    d.arst = 1'b0;
                    if (POST_OS_RESET && INIT_DLY_CYC > 0) begin
                        d.st  = ST_INIT;
                        d.tmr = TW'(INIT_DLY_CYC - 1);
                    end else begin
                        d.st = ST_IDLE;
                    end
                end else begin
                    d.tmr = q.tmr - 1'b1;
                end
            end
            ST_INIT: begin
                if (q.tmr == '0) d.st = ST_IDLE;
                else             d.tmr = q.tmr - 1'b1;
            end
            ST_CONV: begin
                if (busy_fell) begin
                    d.st  = ST_READ;
                    d.ch  = '0;
                    rd_go = 1'b1;
                    if (q.cont) d.cv = 1'b0;
                end else if (!q.cont) begin
                    if (q.tmr == '0) begin
                        d.err_t = 1'b1;
                        d.cv    = 1'b0;
                        d.st    = ST_IDLE;
                    end else begin
                        d.tmr = q.tmr - 1'b1;
                    end
                end
            end
            ST_READ: begin
                if (rd_done) begin
                    if (q.ch == '0 && !rd_first) begin
                        d.err_a = 1'b1;
                        d.cv    = 1'b0;
                        d.cont  = 1'b0;
                        d.st    = ST_RST;
                        d.arst  = 1'b1;
                        d.tmr   = TW'(RST_CYC - 1);
                    end else begin
                        d.vld  = 1'b1;
                        d.word = rd_word;
                        d.st   = ST_SEND;
                    end
                end
            end
            ST_SEND: begin
                if (out_ready) begin
                    d.vld = 1'b0;
                    if (q.ch == CH_W'(NUM_CH - 1)) begin
                        if (q.cont && cont_en) begin
                            d.cv = 1'b1;
                            d.st = ST_CONV;
                        end else begin
                            d.cv   = 1'b0;
                            d.cont = 1'b0;
                            d.st   = ST_IDLE;
                        end
                    end else begin
                        d.ch  = q.ch + 1'b1;
                        d.st  = ST_READ;
                        rd_go = 1'b1;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign conv_start  = q.cv;
    assign adc_reset   = q.arst;
    assign os_pins     = q.os;
    assign range_pin   = q.rng;
    assign out_data    = q.word;
    assign out_ch      = q.ch;
    assign out_valid   = q.vld;
    assign out_last    = (q.ch == CH_W'(NUM_CH - 1));
    assign err_align   = q.err_a;
    assign err_timeout = q.err_t;

    AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ch))
        else $error("beat changed under stall"); // R5
    AST_NO_CONV_WHILE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !$rose(conv_start)) else $error("conversion while beat pending"); // R5
    AST_ALIGN_WITH_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        err_align |-> adc_reset) else $error("align error without reset"); // R6
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        adc_reset |-> !conv_start && rd_n) else $error("activity during reset"); // R7
    AST_TIMEOUT_DROPS_START: assert property (@(posedge clk) disable iff (!rst_n)
        err_timeout |-> !conv_start) else $error("start high after timeout"); // R8
    AST_OS_INDEX_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (NUM_CH != 16) |-> (os_pins != 3'd7)) else $error("illegal os index"); // R9
    AST_STANDBY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> range_pin) else $error("span low in standby"); // R10

endmodule

// File: tb/simul_adc_capture_tb_top.sv
module simul_adc_capture_tb_top;

    localparam int NUM_CH  = 8;
    localparam int DATA_W  = 16;
    localparam int RD_LOW  = 2;
    localparam int RD_HIGH = 1;
    localparam int RST_C   = 5;
    localparam int TOUT    = 400;
    localparam int INIT_C  = 60;
    localparam int CH_W    = $clog2(NUM_CH);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_single = 1'b0, cont_en = 1'b0, range_sel = 1'b0, standby = 1'b0;
    logic [2:0] os_sel = 3'd0;
    logic busy = 1'b0, first_data = 1'b0;
    logic [DATA_W-1:0] rd_data = '0;
    logic conv_start, rd_n, adc_reset, range_pin, out_valid, out_last;
    logic err_align, err_timeout;
    logic out_ready = 1'b1;
    logic [2:0] os_pins;
    logic [DATA_W-1:0] out_data;
    logic [CH_W-1:0] out_ch;

    always #10 clk = ~clk;

    simul_adc_capture #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .RD_LOW_CYC(RD_LOW), .RD_HIGH_CYC(RD_HIGH),
        .RST_CYC(RST_C), .TIMEOUT_CYC(TOUT), .INIT_DLY_CYC(INIT_C), .POST_OS_RESET(1'b1)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_single(start_single), .cont_en(cont_en),
        .os_sel(os_sel), .range_sel(range_sel), .standby(standby), .busy(busy),
        .first_data(first_data), .rd_data(rd_data), .conv_start(conv_start), .rd_n(rd_n),
        .adc_reset(adc_reset), .os_pins(os_pins), .range_pin(range_pin),
        .out_data(out_data), .out_ch(out_ch), .out_valid(out_valid), .out_last(out_last),
        .out_ready(out_ready), .err_align(err_align), .err_timeout(err_timeout)
    );

    int n_chk = 0, n_err = 0;
    int mfr = 0, ridx = 0, beats = 0, frames = 0, bidx = 0;
    bit hang = 1'b0, misalign = 1'b0, rnd_rdy = 1'b0;
    logic [15:0] salt;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] scr(input int fr, input int ch);
        int v;
        v = int'(salt) ^ (fr * 40503) ^ (ch * 4099) ^ (ch << 11);
        return v[15:0];
    endfunction

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic pulse_start();
        tick();
        start_single = 1'b1;
        tick();
        start_single = 1'b0;
    endtask

    task automatic wait_quiet();
        int qc = 0;
        while (qc < 90) begin
            @(negedge clk);
            if (!conv_start && !out_valid && !busy && !adc_reset && rd_n) qc++;
            else qc = 0;
        end
        tick();
    endtask

    // converter model: busy after start, random conversion time
    initial begin
        forever begin
            @(posedge conv_start);
            if (!hang) begin
                int lat;
                lat = 3 + int'($urandom % 10);
                @(posedge clk); #2 busy = 1'b1;
                repeat (lat) @(posedge clk);
                #2 busy = 1'b0;
                mfr++;
                ridx = 0;
            end
        end
    end

    always @(negedge rd_n) begin
        rd_data    = scr(mfr, ridx);
        first_data = (ridx == 0) ? !misalign : 1'b0;
        ridx++;
    end
    // word is garbage after the strobe rises: a late capture is caught (R3)
    always @(posedge rd_n) rd_data = ~rd_data;

    always @(posedge clk) begin
        #2;
        if (rnd_rdy) out_ready = (($urandom % 4) != 0);
    end

    // beat monitor (R2, R4)
    bit last_acc = 1'b0, exp_cv = 1'b0;
    always @(negedge clk) begin
        if (last_acc) begin
            chk(conv_start == exp_cv, exp_cv ? "R4 restart" : "R2 start low", conv_start, exp_cv);
            last_acc = 1'b0;
        end
        if (rst_n && out_valid && out_ready) begin
            chk(int'(out_ch) == bidx, "R2 channel", out_ch, bidx);
            chk(out_data == scr(mfr, bidx), "R2 data", out_data, scr(mfr, bidx));
            chk(out_last == (bidx == NUM_CH - 1), "R2 last", out_last, bidx == NUM_CH - 1);
            beats++;
            if (bidx == NUM_CH - 1) begin
                bidx = 0;
                frames++;
                last_acc = 1'b1;
                exp_cv = cont_en;
            end else begin
                bidx++;
            end
        end
    end

    // continuous mode drops start when busy falls (R4)
    bit bprev = 1'b0, pend = 1'b0, pend_c = 1'b0;
    always @(negedge clk) begin
        if (pend) begin
            if (pend_c) chk(conv_start == 1'b0, "R4 start low at busy fall", conv_start, 0);
            pend = 1'b0;
        end
        if (bprev && !busy) begin
            pend = 1'b1;
            pend_c = cont_en;
        end
        bprev = busy;
    end

    // strobe timing (R3)
    int lrun = 0, hrun = 0;
    bit seen = 1'b0;
    always @(negedge clk) begin
        if (!rst_n) begin
            lrun = 0; hrun = 0; seen = 1'b0;
        end else if (rd_n == 1'b0) begin
            if (lrun == 0 && seen) chk(hrun >= RD_HIGH, "R3 high time", hrun, RD_HIGH);
            lrun++;
            hrun = 0;
        end else begin
            if (lrun > 0) begin
                chk(lrun == RD_LOW, "R3 low time", lrun, RD_LOW);
                seen = 1'b1;
            end
            lrun = 0;
            hrun++;
        end
    end

    task automatic run_all();
        int n, g, b0, f0, guard;
        logic [DATA_W-1:0] held;
        void'($urandom(32'h5A1E));
        salt = 16'($urandom);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(conv_start == 0, "R1 conv_start", conv_start, 0);
        chk(rd_n == 1, "R1 rd_n", rd_n, 1);
        chk(adc_reset == 0, "R1 adc_reset", adc_reset, 0);
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(os_pins == 0, "R1 os_pins", os_pins, 0);
        chk(!err_align && !err_timeout, "R1 errors", err_align | err_timeout, 0);
        tick();
        rst_n = 1'b1;
        tick();

        // R10 span pin
        range_sel = 1'b1; repeat (2) @(negedge clk);
        chk(range_pin == 1, "R10 large span", range_pin, 1);
        tick(); range_sel = 1'b0; repeat (2) @(negedge clk);
        chk(range_pin == 0, "R10 small span", range_pin, 0);
        tick(); standby = 1'b1; repeat (2) @(negedge clk);
        chk(range_pin == 1, "R10 standby forces high", range_pin, 1);
        tick(); standby = 1'b0; repeat (2) @(negedge clk);
        chk(range_pin == 0, "R10 standby release", range_pin, 0);

        // R2 single shot, steady then random ready
        f0 = frames;
        pulse_start();
        wait_quiet();
        chk(frames == f0 + 1, "R2 single frame", frames, f0 + 1);
        rnd_rdy = 1'b1;
        pulse_start();
        wait_quiet();
        rnd_rdy = 1'b0; out_ready = 1'b1;
        chk(frames == f0 + 2, "R2 single frame random ready", frames, f0 + 2);

        // R5 long stall in continuous mode, then R4 random continuous run
        tick();
        out_ready = 1'b0; cont_en = 1'b1;
        guard = 0;
        do begin @(negedge clk); guard++; end while (!out_valid && guard < 1000);
        held = out_data;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            chk(out_valid == 1 && out_data == held, "R5 beat held", out_data, held);
            chk(conv_start == 0, "R5 no conversion while stalled", conv_start, 0);
        end
        tick();
        rnd_rdy = 1'b1;
        f0 = frames;
        guard = 0;
        while (frames < f0 + 20 && guard < 20000) begin @(negedge clk); guard++; end
        chk(frames >= f0 + 20, "R4 continuous frames", frames, f0 + 20);
        tick();
        cont_en = 1'b0;
        wait_quiet();
        rnd_rdy = 1'b0; out_ready = 1'b1;

        // R6 misaligned frame
        b0 = beats;
        misalign = 1'b1;
        pulse_start();
        guard = 0;
        do begin @(negedge clk); guard++; end while (!err_align && guard < 1000);
        chk(err_align == 1, "R6 align error", err_align, 1);
        chk(adc_reset == 1, "R6 reset with error", adc_reset, 1);
        chk(conv_start == 0, "R6 start low", conv_start, 0);
        n = 0;
        while (adc_reset) begin n++; @(negedge clk); end
        chk(n == RST_C, "R7 reset width after misalign", n, RST_C);
        chk(err_align == 0, "R6 error one cycle", err_align, 0);
        misalign = 1'b0;
        wait_quiet();
        chk(beats == b0, "R6 frame dropped", beats, b0);
        f0 = frames;
        pulse_start();
        wait_quiet();
        chk(frames == f0 + 1, "R6 recovery frame", frames, f0 + 1);

        // R8 timeout
        hang = 1'b1;
        pulse_start();
        guard = 0;
        do begin @(negedge clk); guard++; end while (!conv_start && guard < 100);
        n = 0;
        do begin @(negedge clk); n++; end while (!err_timeout && n < TOUT + 20);
        chk(n == TOUT, "R8 timeout cycles", n, TOUT);
        chk(conv_start == 0, "R8 start low", conv_start, 0);
        hang = 1'b0;
        wait_quiet();

        // R9/R7 oversampling change with waiting continuous request
        os_sel = 3'd3; cont_en = 1'b1;
        @(negedge clk);
        guard = 0;
        while (!adc_reset && guard < 100) begin @(negedge clk); guard++; end
        chk(os_pins == 3, "R9 os index", os_pins, 3);
        n = 0;
        while (adc_reset) begin n++; @(negedge clk); end
        chk(n == RST_C, "R7 reset width after os change", n, RST_C);
        g = 0;
        while (!conv_start && g < INIT_C + 50) begin g++; @(negedge clk); end
        chk(g >= INIT_C + 1 && g <= INIT_C + 2, "R7 init delay", g, INIT_C + 1);
        tick();
        cont_en = 1'b0;
        wait_quiet();

        os_sel = 3'd7;
        @(negedge clk);
        guard = 0;
        while (!adc_reset && guard < 100) begin @(negedge clk); guard++; end
        chk(adc_reset == 1, "R9 reset on os change", adc_reset, 1);
        wait_quiet();
        chk(os_pins == 6, "R9 index 7 clamped", os_pins, 6);
        f0 = frames;
        pulse_start();
        wait_quiet();
        chk(frames == f0 + 1, "R2 frame after os change", frames, f0 + 1);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_err++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule